// File: doc/BRIEF.md
# Dual Byte Buffer with Threshold and Frame-Done Interrupts

This block holds the transmit and receive byte queues that sit between a register interface and a serial bus shifter. The register side pushes bytes into the transmit queue and the shifter drains them. The shifter pushes received bytes into the receive queue and the register side drains them. Each queue reports its occupancy and has its own flush pulse.

Interrupt status is built from four sources. Two are level sources: the receive queue holding at least its trigger level, and the transmit queue holding at most its trigger level. The other two are sticky frame-done events for each direction. An enable mask selects which sources drive the single interrupt output.

For the receive side, the block also keeps a running count of every byte accepted into the queue and a small count of bytes read out. Only a receive flush clears these two counts.

Top module: `bbuf_top`

## Requirements
- R1: Each queue delivers bytes in the order they were accepted. The read data port always shows the oldest stored byte, and a pop removes it at the clock edge.
- R2: A queue's occupancy rises by one on an accepted push, falls by one on an accepted pop, and is unchanged when both happen in one cycle. `buf_cnt[3:0]` carries the receive occupancy and `buf_cnt[7:4]` the transmit occupancy.
- R3: A push into a full queue (DEPTH bytes) is dropped and stores nothing. A pop from an empty queue is dropped. Neither changes the occupancy or the counts.
- R4: A flush pulse empties its own queue at the next edge and cancels any push or pop in the same cycle. A receive flush also zeroes `rx_total` and `rx_rdcnt`. A flush of one queue leaves the other queue untouched.
- R5: `irq_sts[3]` is 1 exactly when the receive occupancy is greater than or equal to `rx_lvl`. It follows the occupancy with no delay.
- R6: `irq_sts[1]` is 1 exactly when the transmit occupancy is less than or equal to `tx_lvl`. It follows the occupancy with no delay.
- R7: A `tx_frame_done` pulse sets `irq_sts[0]`, and an `rx_frame_done` pulse sets `irq_sts[2]`, one cycle later. Each bit then stays set until a 1 is written to the same position of `irq_w1c`. A set and a clear in the same cycle leave the bit set. Writing 1 to positions 1 or 3 of `irq_w1c` has no effect.
- R8: `irq` is the OR of `irq_sts & irq_en`, with the enable bits in the same positions as the status bits.
- R9: `rx_total` is 8 bits wide. It increments on every accepted receive push, wraps modulo 256, and is not changed by pops.
- R10: `rx_rdcnt` is 3 bits wide. It increments on every accepted receive pop and wraps modulo 8.
- R11: After reset both queues are empty, both counts are zero, and both done status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr_en | input | 1 | Push a byte into the transmit queue |
| tx_wr_data | input | 8 | Byte to push into the transmit queue |
| tx_rd_en | input | 1 | Shifter pops the transmit queue |
| tx_rd_data | output | 8 | Oldest byte in the transmit queue |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_wr_en | input | 1 | Shifter pushes a byte into the receive queue |
| rx_wr_data | input | 8 | Byte to push into the receive queue |
| rx_rd_en | input | 1 | Register side pops the receive queue |
| rx_rd_data | output | 8 | Oldest byte in the receive queue |
| rx_flush | input | 1 | Empty the receive queue and clear its counts |
| tx_lvl | input | 4 | Transmit trigger level |
| rx_lvl | input | 4 | Receive trigger level |
| tx_frame_done | input | 1 | Pulse at the end of a sent frame |
| rx_frame_done | input | 1 | Pulse at the end of a received frame |
| irq_en | input | 4 | Interrupt enables, in status bit order |
| irq_w1c | input | 4 | Write-1-to-clear pulses for the done status bits |
| buf_cnt | output | 8 | {transmit occupancy, receive occupancy} |
| rx_total | output | 8 | Accumulated count of accepted receive bytes |
| rx_rdcnt | output | 3 | Count of bytes popped from the receive queue |
| irq_sts | output | 4 | {rx level, rx done, tx level, tx done} |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the transmit queue past DEPTH and checks two things. The occupancy must stay at DEPTH, and the dropped byte must never appear in the drained data. A design that let the count or pointers run on would show a wrong count or a stale byte. It also drives a simultaneous push and pop, including on an empty queue where only the push may take effect; a design that honoured that pop would lose a byte or underflow the count. It issues a flush together with a push to check that flush wins, and runs several hundred push-and-pop cycles to check that the receive byte total wraps at 256 and the read count wraps at 8. It sweeps both trigger levels through all sixteen values to catch an off-by-one or reversed comparison. It also asserts a frame-done pulse and its clear in the same cycle; a design where clear won would drop a real event.

// File: rtl/bbuf_pkg.sv
package bbuf_pkg;

    // Status bit positions; the enable vector uses the same order.
    localparam int unsigned ST_TX_DONE = 0;
    localparam int unsigned ST_TX_LVL  = 1;
    localparam int unsigned ST_RX_DONE = 2;
    localparam int unsigned ST_RX_LVL  = 3;
    localparam int unsigned ST_W       = 4;

    // Queue index inside the top-level generate.
    localparam int unsigned Q_TX = 0;
    localparam int unsigned Q_RX = 1;
    localparam int unsigned Q_N  = 2;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_req_t;

endpackage

// File: rtl/bbuf_fifo.sv
module bbuf_fifo
    import bbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fifo_req_t     req,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] cnt,
    output logic          push_ok,
    output logic          pop_ok
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = req.push && !req.flush && (st_q.cnt != FULL);
        pop_ok  = req.pop  && !req.flush && (st_q.cnt != '0);
        if (req.flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = ptr_next(st_q.wp);
            if (pop_ok)  st_d.rp = ptr_next(st_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign cnt   = st_q.cnt;

endmodule

// File: rtl/bbuf_rxacc.sv
module bbuf_rxacc #(
    parameter int unsigned TW = 8,
    parameter int unsigned RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic          flush,
    output logic [TW-1:0] total,
    output logic [RW-1:0] rdcnt
);

    typedef struct packed {
        logic [TW-1:0] total;
        logic [RW-1:0] rdcnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.total = st_q.total + TW'(1);
            if (pop_ok)  st_d.rdcnt = st_q.rdcnt + RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total = st_q.total;
    assign rdcnt = st_q.rdcnt;

endmodule

// File: rtl/bbuf_irq.sv
module bbuf_irq
    import bbuf_pkg::*;
#(
    parameter int unsigned CW = 4,
    parameter int unsigned LW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   tx_cnt,
    input  logic [CW-1:0]   rx_cnt,
    input  logic [LW-1:0]   tx_lvl,
    input  logic [LW-1:0]   rx_lvl,
    input  logic            tx_done_ev,
    input  logic            rx_done_ev,
    input  logic [ST_W-1:0] w1c,
    input  logic [ST_W-1:0] en,
    output logic [ST_W-1:0] sts,
    output logic            irq
);

    localparam int unsigned MW = (CW > LW) ? CW : LW;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
    } state_t;

    state_t st_d, st_q;
    logic   tx_hit, rx_hit;
    logic [1:0] lvl_clr_unused;

    assign lvl_clr_unused = {w1c[ST_TX_LVL], w1c[ST_RX_LVL]};

    // A new event wins over a clear arriving in the same cycle.
    always_comb begin
        st_d         = st_q;
        st_d.tx_done = tx_done_ev | (st_q.tx_done & ~w1c[ST_TX_DONE]);
        st_d.rx_done = rx_done_ev | (st_q.rx_done & ~w1c[ST_RX_DONE]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_hit = MW'(rx_cnt) >= MW'(rx_lvl);
    assign tx_hit = MW'(tx_cnt) <= MW'(tx_lvl);

    always_comb begin
        sts             = '0;
        sts[ST_TX_DONE] = st_q.tx_done;
        sts[ST_TX_LVL]  = tx_hit;
        sts[ST_RX_DONE] = st_q.rx_done;
        sts[ST_RX_LVL]  = rx_hit;
    end

    assign irq = |(sts & en);

endmodule

// File: rtl/bbuf_top.sv
module bbuf_top
    import bbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    parameter int unsigned LW    = 4,
    parameter int unsigned TW    = 8,
    parameter int unsigned RW    = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_wr_en,
    input  logic [DW-1:0]   tx_wr_data,
    input  logic            tx_rd_en,
    output logic [DW-1:0]   tx_rd_data,
    input  logic            tx_flush,
    input  logic            rx_wr_en,
    input  logic [DW-1:0]   rx_wr_data,
    input  logic            rx_rd_en,
    output logic [DW-1:0]   rx_rd_data,
    input  logic            rx_flush,
    input  logic [LW-1:0]   tx_lvl,
    input  logic [LW-1:0]   rx_lvl,
    input  logic            tx_frame_done,
    input  logic            rx_frame_done,
    input  logic [ST_W-1:0] irq_en,
    input  logic [ST_W-1:0] irq_w1c,
    output logic [2*CW-1:0] buf_cnt,
    output logic [TW-1:0]   rx_total,
    output logic [RW-1:0]   rx_rdcnt,
    output logic [ST_W-1:0] irq_sts,
    output logic            irq
);

    fifo_req_t     req     [Q_N];
    logic [DW-1:0] wdat    [Q_N];
    logic [DW-1:0] rdat    [Q_N];
    logic [CW-1:0] cnt     [Q_N];
    logic          push_ok [Q_N];
    logic          pop_ok  [Q_N];
    logic          tx_ok_unused;

    assign req[Q_TX]  = '{push: tx_wr_en, pop: tx_rd_en, flush: tx_flush};
    assign req[Q_RX]  = '{push: rx_wr_en, pop: rx_rd_en, flush: rx_flush};
    assign wdat[Q_TX] = tx_wr_data;
    assign wdat[Q_RX] = rx_wr_data;

    for (genvar g = 0; g < Q_N; g++) begin : g_q
        bbuf_fifo #(
            .DEPTH (DEPTH),
            .DW    (DW),
            .CW    (CW)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[g]),
            .wdata   (wdat[g]),
            .rdata   (rdat[g]),
            .cnt     (cnt[g]),
            .push_ok (push_ok[g]),
            .pop_ok  (pop_ok[g])
        );
    end

    assign tx_ok_unused = push_ok[Q_TX] ^ pop_ok[Q_TX];

    bbuf_rxacc #(
        .TW (TW),
        .RW (RW)
    ) u_rxacc (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_ok (push_ok[Q_RX]),
        .pop_ok  (pop_ok[Q_RX]),
        .flush   (rx_flush),
        .total   (rx_total),
        .rdcnt   (rx_rdcnt)
    );

    bbuf_irq #(
        .CW (CW),
        .LW (LW)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_cnt     (cnt[Q_TX]),
        .rx_cnt     (cnt[Q_RX]),
        .tx_lvl     (tx_lvl),
        .rx_lvl     (rx_lvl),
        .tx_done_ev (tx_frame_done),
        .rx_done_ev (rx_frame_done),
        .w1c        (irq_w1c),
        .en         (irq_en),
        .sts        (irq_sts),
        .irq        (irq)
    );

    assign tx_rd_data = rdat[Q_TX];
    assign rx_rd_data = rdat[Q_RX];
    assign buf_cnt    = {cnt[Q_TX], cnt[Q_RX]};

endmodule

// File: rtl/bbuf_chk.sv
module bbuf_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LW    = 4,
    parameter int unsigned TW    = 8,
    parameter int unsigned RW    = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_wr_en,
    input logic            tx_rd_en,
    input logic            tx_flush,
    input logic            rx_wr_en,
    input logic            rx_rd_en,
    input logic            rx_flush,
    input logic [LW-1:0]   tx_lvl,
    input logic [LW-1:0]   rx_lvl,
    input logic            tx_frame_done,
    input logic            rx_frame_done,
    input logic [3:0]      irq_en,
    input logic [2*CW-1:0] buf_cnt,
    input logic [TW-1:0]   rx_total,
    input logic [RW-1:0]   rx_rdcnt,
    input logic [3:0]      irq_sts,
    input logic            irq
);

    localparam int unsigned MW = (CW > LW) ? CW : LW;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] tx_cnt, rx_cnt;
    assign rx_cnt = buf_cnt[CW-1:0];
    assign tx_cnt = buf_cnt[2*CW-1:CW];

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= FULL) && (rx_cnt <= FULL));

    p_full_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && !tx_rd_en && !tx_flush && tx_cnt == FULL) |=> (tx_cnt == FULL));

    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && !rx_wr_en && !rx_flush && rx_cnt == '0) |=> (rx_cnt == '0) && $stable(rx_rdcnt));

    p_flush_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_cnt == '0) && (rx_total == '0) && (rx_rdcnt == '0));

    p_flush_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_cnt == '0));

    p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sts[3] == (MW'(rx_cnt) >= MW'(rx_lvl)));

    p_tx_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sts[1] == (MW'(tx_cnt) <= MW'(tx_lvl)));

    p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_done |=> irq_sts[0]);

    p_rx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_done |=> irq_sts[2]);

    p_irq_combine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(irq_sts & irq_en));

    p_total_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr_en && !rx_flush && rx_cnt != FULL) |=> (rx_total == TW'($past(rx_total) + TW'(1))));

endmodule

bind bbuf_top bbuf_chk #(
    .DEPTH (DEPTH),
    .LW    (LW),
    .TW    (TW),
    .RW    (RW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_wr_en      (tx_wr_en),
    .tx_rd_en      (tx_rd_en),
    .tx_flush      (tx_flush),
    .rx_wr_en      (rx_wr_en),
    .rx_rd_en      (rx_rd_en),
    .rx_flush      (rx_flush),
    .tx_lvl        (tx_lvl),
    .rx_lvl        (rx_lvl),
    .tx_frame_done (tx_frame_done),
    .rx_frame_done (rx_frame_done),
    .irq_en        (irq_en),
    .buf_cnt       (buf_cnt),
    .rx_total      (rx_total),
    .rx_rdcnt      (rx_rdcnt),
    .irq_sts       (irq_sts),
    .irq           (irq)
);

// File: tb/sim_bbuf_top.sv
`timescale 1ns/1ps
module sim_bbuf_top;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_wr_en = 0, tx_rd_en = 0, tx_flush = 0;
    logic       rx_wr_en = 0, rx_rd_en = 0, rx_flush = 0;
    logic [7:0] tx_wr_data = 0, rx_wr_data = 0;
    logic [7:0] tx_rd_data, rx_rd_data;
    logic [3:0] tx_lvl = 0, rx_lvl = 0;
    logic       tx_frame_done = 0, rx_frame_done = 0;
    logic [3:0] irq_en = 0, irq_w1c = 0;
    logic [7:0] buf_cnt, rx_total;
    logic [2:0] rx_rdcnt;
    logic [3:0] irq_sts;
    logic       irq;

    bbuf_top u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en),
        .tx_rd_data(tx_rd_data), .tx_flush(tx_flush),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .rx_flush(rx_flush),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_frame_done(tx_frame_done), .rx_frame_done(rx_frame_done),
        .irq_en(irq_en), .irq_w1c(irq_w1c),
        .buf_cnt(buf_cnt), .rx_total(rx_total), .rx_rdcnt(rx_rdcnt),
        .irq_sts(irq_sts), .irq(irq)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model and scoreboard
    logic [7:0] mtx[$], mrx[$], exp_tx[$], exp_rx[$];
    logic [7:0] m_total = 0;
    logic [2:0] m_rdcnt = 0;
    logic       m_txd = 0, m_rxd = 0;
    bit         tx_pop_ok = 0, rx_pop_ok = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares read data with the expected item when a pop is accepted.
    always @(negedge clk) begin
        if (tx_pop_ok) begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(tx_rd_data == e, "R1 tx order", int'(tx_rd_data), int'(e));
        end
        if (rx_pop_ok) begin
            logic [7:0] e;
            e = exp_rx.pop_front();
            chk(rx_rd_data == e, "R1 rx order", int'(rx_rd_data), int'(e));
        end
    end

    function automatic logic [3:0] exp_sts();
        return {(mrx.size() >= int'(rx_lvl)), m_rxd, (mtx.size() <= int'(tx_lvl)), m_txd};
    endfunction

    task automatic compare_all();
        logic [3:0] s;
        s = exp_sts();
        chk(int'(buf_cnt[3:0]) == mrx.size(), "R2 rx occupancy", int'(buf_cnt[3:0]), mrx.size());
        chk(int'(buf_cnt[7:4]) == mtx.size(), "R2 tx occupancy", int'(buf_cnt[7:4]), mtx.size());
        chk(rx_total == m_total, "R9 rx total", int'(rx_total), int'(m_total));
        chk(rx_rdcnt == m_rdcnt, "R10 rx read count", int'(rx_rdcnt), int'(m_rdcnt));
        chk(irq_sts[3] == s[3], "R5 rx level status", int'(irq_sts[3]), int'(s[3]));
        chk(irq_sts[1] == s[1], "R6 tx level status", int'(irq_sts[1]), int'(s[1]));
        chk({irq_sts[2], irq_sts[0]} == {s[2], s[0]}, "R7 done status",
            int'({irq_sts[2], irq_sts[0]}), int'({s[2], s[0]}));
        chk(irq == |(s & irq_en), "R8 combined irq", int'(irq), int'(|(s & irq_en)));
    endtask

    // Driver: called at posedge+1; applies one cycle of stimulus, updates the model.
    task automatic step(input bit txw = 0, input logic [7:0] txd = 0, input bit txr = 0,
                        input bit rxw = 0, input logic [7:0] rxd = 0, input bit rxr = 0,
                        input bit txf = 0, input bit rxf = 0,
                        input bit tfd = 0, input bit rfd = 0, input logic [3:0] w1c = 0);
        bit tpush, tpop, rpush, rpop;
        tx_wr_en = txw; tx_wr_data = txd; tx_rd_en = txr; tx_flush = txf;
        rx_wr_en = rxw; rx_wr_data = rxd; rx_rd_en = rxr; rx_flush = rxf;
        tx_frame_done = tfd; rx_frame_done = rfd; irq_w1c = w1c;
        tpush = txw && !txf && mtx.size() < DEPTH;
        tpop  = txr && !txf && mtx.size() > 0;
        rpush = rxw && !rxf && mrx.size() < DEPTH;
        rpop  = rxr && !rxf && mrx.size() > 0;
        if (tpop) exp_tx.push_back(mtx[0]);
        if (rpop) exp_rx.push_back(mrx[0]);
        tx_pop_ok = tpop;
        rx_pop_ok = rpop;
        if (txf) mtx.delete();
        else begin
            if (tpop)  void'(mtx.pop_front());
            if (tpush) mtx.push_back(txd);
        end
        if (rxf) begin
            mrx.delete(); m_total = 0; m_rdcnt = 0;
        end else begin
            if (rpop)  begin void'(mrx.pop_front()); m_rdcnt = m_rdcnt + 3'd1; end
            if (rpush) begin mrx.push_back(rxd); m_total = m_total + 8'd1; end
        end
        m_txd = tfd | (m_txd & ~w1c[0]);
        m_rxd = rfd | (m_rxd & ~w1c[2]);
        @(posedge clk); #1;
        tx_wr_en = 0; tx_rd_en = 0; tx_flush = 0;
        rx_wr_en = 0; rx_rd_en = 0; rx_flush = 0;
        tx_frame_done = 0; rx_frame_done = 0; irq_w1c = 0;
        tx_pop_ok = 0; rx_pop_ok = 0;
        compare_all();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rx_lvl = 4'd2; tx_lvl = 4'd1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R11 reset state
        chk(buf_cnt == 8'h00, "R11 reset occupancy", int'(buf_cnt), 0);
        chk(rx_total == 8'h00 && rx_rdcnt == 3'd0, "R11 reset counts", int'(rx_total), 0);
        chk({irq_sts[2], irq_sts[0]} == 2'b00, "R11 reset done bits", int'(irq_sts), 0);
        compare_all();

        // R1 R2: plain transmit traffic
        for (int i = 0; i < 5; i++) step(.txw(1), .txd(8'hA0 + 8'(i)));
        for (int i = 0; i < 5; i++) step(.txr(1));

        // R3: overfill and overdrain the transmit queue
        for (int i = 0; i < DEPTH; i++) step(.txw(1), .txd(8'(i * 17 + 3)));
        step(.txw(1), .txd(8'hEE));
        chk(buf_cnt[7:4] == 4'd8, "R3 push into full dropped", int'(buf_cnt[7:4]), 8);
        for (int i = 0; i < DEPTH; i++) step(.txr(1));
        step(.txr(1));
        chk(buf_cnt[7:4] == 4'd0, "R3 pop from empty dropped", int'(buf_cnt[7:4]), 0);
        step(.txr(1), .txw(1), .txd(8'h5A));
        chk(buf_cnt[7:4] == 4'd1, "R3 pop on empty with push", int'(buf_cnt[7:4]), 1);
        step(.txr(1));

        // R2 R10: receive traffic with simultaneous push and pop
        for (int i = 0; i < 3; i++) step(.rxw(1), .rxd(8'h30 + 8'(i)));
        for (int i = 0; i < 4; i++) step(.rxw(1), .rxd(8'h40 + 8'(i)), .rxr(1));
        for (int i = 0; i < 3; i++) step(.rxr(1));
        step(.rxr(1));
        chk(rx_rdcnt == 3'd7, "R3 rx pop on empty leaves read count", int'(rx_rdcnt), 7);

        // R5 R6: sweep trigger levels
        for (int i = 0; i < 3; i++) step(.rxw(1), .rxd(8'h50 + 8'(i)));
        for (int i = 0; i < 2; i++) step(.txw(1), .txd(8'h60 + 8'(i)));
        for (int lv = 0; lv < 16; lv++) begin
            rx_lvl = 4'(lv); tx_lvl = 4'(lv);
            #1;
            chk(irq_sts[3] == (lv <= 3), "R5 rx level sweep", int'(irq_sts[3]), int'(lv <= 3));
            chk(irq_sts[1] == (lv >= 2), "R6 tx level sweep", int'(irq_sts[1]), int'(lv >= 2));
        end
        rx_lvl = 4'd4; tx_lvl = 4'd0;
        step();

        // R4: flush wins over same-cycle push, other queue untouched
        step(.rxw(1), .rxd(8'h99), .rxf(1));
        chk(buf_cnt[3:0] == 4'd0, "R4 rx flush empties", int'(buf_cnt[3:0]), 0);
        chk(rx_total == 8'd0 && rx_rdcnt == 3'd0, "R4 rx flush clears counts", int'(rx_total), 0);
        chk(buf_cnt[7:4] == 4'd2, "R4 tx kept on rx flush", int'(buf_cnt[7:4]), 2);
        step(.txr(1), .txf(1));
        chk(buf_cnt[7:4] == 4'd0, "R4 tx flush empties", int'(buf_cnt[7:4]), 0);

        // R9 R10: long run to wrap both counters
        step(.rxw(1), .rxd(8'h01));
        for (int i = 0; i < 300; i++) step(.rxw(1), .rxd(8'(i + 2)), .rxr(1));
        chk(rx_total == 8'd45, "R9 total wraps at 256", int'(rx_total), 45);
        chk(rx_rdcnt == 3'd4, "R10 read count wraps at 8", int'(rx_rdcnt), 4);
        step(.rxr(1));
        chk(rx_total == 8'd45, "R9 pop leaves total", int'(rx_total), 45);

        // R7 R8: done events, clear, enables
        tx_lvl = 4'd0; rx_lvl = 4'd1; irq_en = 4'b0000;
        step(.tfd(1));
        chk(irq_sts[0] == 1'b1, "R7 tx done set", int'(irq_sts[0]), 1);
        chk(irq == 1'b0, "R8 masked", int'(irq), 0);
        irq_en = 4'b0001; #1;
        chk(irq == 1'b1, "R8 tx done enabled", int'(irq), 1);
        step(.w1c(4'b1010));
        chk(irq_sts[0] == 1'b1, "R7 clear on level positions ignored", int'(irq_sts[0]), 1);
        step(.tfd(1), .w1c(4'b0001));
        chk(irq_sts[0] == 1'b1, "R7 set wins over clear", int'(irq_sts[0]), 1);
        step(.w1c(4'b0001));
        chk(irq_sts[0] == 1'b0 && irq == 1'b0, "R7 tx done cleared", int'(irq_sts[0]), 0);
        irq_en = 4'b0100;
        step(.rfd(1));
        chk(irq_sts[2] == 1'b1 && irq == 1'b1, "R7 rx done set", int'(irq_sts[2]), 1);
        step(.w1c(4'b0100));
        chk(irq_sts[2] == 1'b0, "R7 rx done cleared", int'(irq_sts[2]), 0);
        irq_en = 4'b1000; rx_lvl = 4'd0; #1;
        chk(irq == 1'b1, "R8 rx level enabled", int'(irq), 1);
        irq_en = 4'b0010; tx_lvl = 4'd0; #1;
        chk(irq == 1'b1, "R8 tx level enabled", int'(irq), 1);
        step();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule